// File: doc/BRIEF.md
# Byte-Serial Load Instruction Sequencer

This block fetches and runs the byte-load subset of a classic 8-bit accumulator instruction set. It uses a plain synchronous memory bus and moves one byte per machine cycle. It holds seven 8-bit working registers (B, C, D, E, H, L, A) and two 16-bit index pointers (X and Y). It also holds a 16-bit program counter that starts at `RESET_PC`. H and L together form the 16-bit memory pointer HL. The supported instructions are:

- register-to-register copy
- load of an immediate byte
- load from and store to the byte that HL points at
- load and store at an index pointer plus a signed displacement, selected by a one-byte prefix

The bus strobes follow a fixed per-instruction schedule. One clock state is one clock cycle. A machine cycle spans a fixed number of clock states.

The sequencer is a state machine with these states:

- `ST_FETCH`: opcode fetch, 4 states.
- `ST_XFETCH`: opcode fetch after a prefix, 4 states.
- `ST_IMM`: immediate read, 3 states.
- `ST_DISP`: displacement read, 3 states.
- `ST_CALC`: internal address cycle with no strobe, 5 states.
- `ST_MRD`: data read, 3 states.
- `ST_MWR`: data write, 3 states.
- `ST_HALT`: stopped.

All transitions happen on the last clock state of a machine cycle:

- From `ST_FETCH`:
  - to `ST_FETCH` after a copy or an unsupported opcode
  - to `ST_IMM`, `ST_MRD` or `ST_MWR` for the immediate and HL forms
  - to `ST_XFETCH` on a prefix
  - to `ST_HALT` on the halt opcode
- From `ST_XFETCH`: to `ST_DISP` for an indexed form, otherwise back to `ST_FETCH`.
- `ST_DISP` goes to `ST_CALC`.
- `ST_CALC` goes to `ST_MRD` or `ST_MWR`.
- `ST_IMM`, `ST_MRD` and `ST_MWR` return to `ST_FETCH`.
- `ST_HALT` stays in `ST_HALT` until reset.

HL, X and Y can also be loaded through a side load port, which test and bring-up code uses to set pointers.

Top module: `ldseq_core`

## Requirements
- R1: Reset clears every working register and both index pointers. It sets the program counter to `RESET_PC` and drops halt, retire and illegal. In the first cycle after reset the block reads from `RESET_PC`.
- R2: Register fields use B=000, C=001, D=010, E=011, H=100, L=101 and A=111. Opcode 01 ddd sss, with neither field 110, copies register sss into register ddd. It is one read machine cycle of 4 states.
- R3: Opcode 00 ddd 110 with ddd not 110 loads the next byte into register ddd. It takes 4 read states at the opcode address, then 3 read states at the next address.
- R4: Opcode 01 ddd 110 with ddd not 110 loads register ddd from the byte at HL. It takes 4 fetch states, then 3 read states with HL on the address bus.
- R5: Opcode 01110 sss with sss not 110 writes register sss to address HL. It takes 4 fetch states, then 3 write states. Address and data are held steady while the write strobe is high, and the read and write strobes are never high together.
- R6: Opcode 0x76 is a halt. After its 4-state fetch, `halted` goes high and stays high until reset. No further strobes occur and no retire pulse is given.
- R7: Prefix 0xDD selects X and prefix 0xFD selects Y. They turn the HL-addressed load (R4) and store (R5) into indexed forms. The byte order is prefix, opcode, displacement. The timing is 4 read, 4 read, 3 read, 5 states with no strobe, then 3 read or 3 write states at the computed address: 19 states in all.
- R8: The displacement is a two's-complement byte from -128 to 127. It is added to the selected pointer modulo 65536.
- R9: The program counter steps by one for each opcode, prefix, immediate and displacement byte, and wraps from 0xFFFF to 0x0000.
- R10: Any other opcode gives a one-cycle `illegal` pulse and is skipped in 4 fetch states. This includes 0x00, and a prefix followed by anything other than an indexed load or store, such as a second prefix or 0x76. In the prefix case the prefix and the following byte are skipped in 8 states and the pulse is given after the second byte. `illegal` and `retire` are never high together.
- R11: With `dbg_we` high, `dbg_sel` 00 loads HL, 01 loads X and 10 loads Y from `dbg_val` at the clock edge. If an instruction writes H or L on the same edge, the side load wins.
- R12: `retire` is high for exactly the one cycle that follows the last clock state of each completed load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | AW | Bus address |
| mem_rd | output | 1 | Read strobe, held for the whole read machine cycle |
| mem_wr | output | 1 | Write strobe, held for the whole write machine cycle |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, taken on the last state of a read machine cycle |
| dbg_we | input | 1 | Side load enable |
| dbg_sel | input | 2 | Side load target: 00 HL, 01 X, 10 Y |
| dbg_val | input | AW | Side load value |
| retire | output | 1 | One-cycle pulse after a completed load |
| illegal | output | 1 | One-cycle pulse after a skipped opcode |
| halted | output | 1 | High from halt until reset |

## Verification
The block has one real collision between functions: a side load of HL can land on the same clock edge where a load instruction writes H or L. The bench provokes it by raising the side load exactly in the last state of an immediate load into H. It then stores H and L through a Y-indexed store. The collision is judged right when the memory holds the side-load bytes rather than the immediate. The bench also compares the full per-cycle strobe, address, retire and illegal traces against schedules it builds itself, over all 49 copy pairs. Every program sits across the 0xFFFF wrap of the program counter.

// File: rtl/ldseq_pkg.sv
package ldseq_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_XFETCH,
        ST_IMM,
        ST_DISP,
        ST_CALC,
        ST_MRD,
        ST_MWR,
        ST_HALT
    } seq_state_e;

    typedef enum logic [2:0] {
        OC_MOVE,
        OC_IMM,
        OC_LDM,
        OC_STM,
        OC_PFX,
        OC_HALT,
        OC_BAD
    } op_class_e;

    typedef struct packed {
        op_class_e  cls;
        logic [2:0] dst;
        logic [2:0] src;
        logic       use_y;
    } op_info_t;

    localparam logic [2:0] FLD_MEM  = 3'b110;
    localparam logic [2:0] FLD_H    = 3'b100;
    localparam logic [2:0] FLD_L    = 3'b101;
    localparam logic [7:0] PFX_X    = 8'hDD;
    localparam logic [7:0] PFX_Y    = 8'hFD;
    localparam logic [7:0] OP_STOP  = 8'h76;
    localparam logic [1:0] SIDE_HL  = 2'd0;
    localparam logic [1:0] SIDE_X   = 2'd1;
    localparam logic [1:0] SIDE_Y   = 2'd2;

    // index of the last clock state of each machine cycle
    function automatic logic [2:0] last_state(input seq_state_e s);
        case (s)
            ST_FETCH, ST_XFETCH: return 3'd3;
            ST_CALC:             return 3'd4;
            ST_HALT:             return 3'd0;
            default:             return 3'd2;
        endcase
    endfunction

endpackage

// File: rtl/ldseq_decode.sv
module ldseq_decode
    import ldseq_pkg::*;
(
    input  logic [7:0] op,
    input  logic       after_pfx,
    output op_info_t   info
);
    logic is_ld_grp;
    logic src_mem;
    logic dst_mem;

    assign is_ld_grp = (op[7:6] == 2'b01);
    assign src_mem   = (op[2:0] == FLD_MEM);
    assign dst_mem   = (op[5:3] == FLD_MEM);

    always_comb begin
        info.dst   = op[5:3];
        info.src   = op[2:0];
        info.use_y = op[5];
        info.cls   = OC_BAD;
        if (after_pfx) begin
            if (is_ld_grp && !(src_mem && dst_mem)) begin
                if (src_mem)      info.cls = OC_LDM;
                else if (dst_mem) info.cls = OC_STM;
            end
        end else if (op == PFX_X || op == PFX_Y) begin
            info.cls = OC_PFX;
        end else if (op == OP_STOP) begin
            info.cls = OC_HALT;
        end else if (is_ld_grp) begin
            if (src_mem)      info.cls = OC_LDM;
            else if (dst_mem) info.cls = OC_STM;
            else              info.cls = OC_MOVE;
        end else if (op[7:6] == 2'b00 && src_mem && !dst_mem) begin
            info.cls = OC_IMM;
        end
    end
endmodule

// File: rtl/ldseq_regs.sv
module ldseq_regs
    import ldseq_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    rsel,
    output logic [DW-1:0] rdat,
    input  logic          we,
    input  logic [2:0]    wsel,
    input  logic [DW-1:0] wdat,
    input  logic          dbg_we,
    input  logic [1:0]    dbg_sel,
    input  logic [AW-1:0] dbg_val,
    output logic [AW-1:0] hl,
    output logic [AW-1:0] ix,
    output logic [AW-1:0] iy
);
    localparam int NREG = 8;

    logic [DW-1:0] gpr_q [NREG];
    logic [AW-1:0] ix_q, iy_q;
    logic          side_hl;

    assign side_hl = dbg_we && (dbg_sel == SIDE_HL);

    for (genvar i = 0; i < NREG; i++) begin : g_gpr
        logic          side_hit;
        logic [DW-1:0] side_byte;
        if (i == int'(FLD_H)) begin : g_hi
            assign side_hit  = side_hl;
            assign side_byte = dbg_val[AW-1 -: DW];
        end else if (i == int'(FLD_L)) begin : g_lo
            assign side_hit  = side_hl;
            assign side_byte = dbg_val[DW-1:0];
        end else begin : g_plain
            assign side_hit  = 1'b0;
            assign side_byte = '0;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)                     gpr_q[i] <= '0;
            else if (side_hit)              gpr_q[i] <= side_byte;
            else if (we && wsel == 3'(i))   gpr_q[i] <= wdat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ix_q <= '0;
            iy_q <= '0;
        end else if (dbg_we) begin
            if (dbg_sel == SIDE_X) ix_q <= dbg_val;
            if (dbg_sel == SIDE_Y) iy_q <= dbg_val;
        end
    end

    assign rdat = gpr_q[rsel];
    assign hl   = {gpr_q[FLD_H], gpr_q[FLD_L]};
    assign ix   = ix_q;
    assign iy   = iy_q;

    // R11
    side_x_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_we && dbg_sel == SIDE_X) |=> (ix == $past(dbg_val)));

    // R11
    side_hl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        side_hl |=> (hl == $past(dbg_val)));
endmodule

// File: rtl/ldseq_agu.sv
module ldseq_agu #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] ea
);
    localparam int EXT = AW - DW;

    assign ea = base + {{EXT{disp[DW-1]}}, disp};
endmodule

// File: rtl/ldseq_core.sv
module ldseq_core
    import ldseq_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          dbg_we,
    input  logic [1:0]    dbg_sel,
    input  logic [AW-1:0] dbg_val,
    output logic          retire,
    output logic          illegal,
    output logic          halted
);
    seq_state_e    st_q, st_d;
    logic [2:0]    tcnt_q, tcnt_d;
    logic [AW-1:0] pc_q, pc_d, maddr_q, maddr_d;
    logic [DW-1:0] wbyte_q, wbyte_d;
    logic [2:0]    dst_q, dst_d;
    logic          usey_q, usey_d, xwr_q, xwr_d;
    logic          ret_q, ret_d, ill_q, ill_d;
    logic          last;

    op_info_t      info;
    logic          g_we;
    logic [2:0]    g_sel;
    logic [DW-1:0] g_dat, rdat;
    logic [AW-1:0] hl, ix, iy, ea;

    ldseq_decode u_dec (
        .op        (mem_rdata),
        .after_pfx (st_q == ST_XFETCH),
        .info      (info)
    );

    ldseq_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rsel    (info.src),
        .rdat    (rdat),
        .we      (g_we),
        .wsel    (g_sel),
        .wdat    (g_dat),
        .dbg_we  (dbg_we),
        .dbg_sel (dbg_sel),
        .dbg_val (dbg_val),
        .hl      (hl),
        .ix      (ix),
        .iy      (iy)
    );

    ldseq_agu #(.AW(AW), .DW(DW)) u_agu (
        .base (usey_q ? iy : ix),
        .disp (mem_rdata),
        .ea   (ea)
    );

    assign last = (tcnt_q == last_state(st_q));

    // next state and datapath control
    always_comb begin
        st_d    = st_q;
        pc_d    = pc_q;
        maddr_d = maddr_q;
        wbyte_d = wbyte_q;
        dst_d   = dst_q;
        usey_d  = usey_q;
        xwr_d   = xwr_q;
        ret_d   = 1'b0;
        ill_d   = 1'b0;
        g_we    = 1'b0;
        g_sel   = dst_q;
        g_dat   = mem_rdata;
        tcnt_d  = last ? 3'd0 : tcnt_q + 3'd1;
        if (last) begin
            unique case (st_q)
                ST_FETCH: begin
                    pc_d = pc_q + 1'b1;
                    unique case (info.cls)
                        OC_MOVE: begin
                            g_we  = 1'b1;
                            g_sel = info.dst;
                            g_dat = rdat;
                            ret_d = 1'b1;
                        end
                        OC_IMM: begin
                            dst_d = info.dst;
                            st_d  = ST_IMM;
                        end
                        OC_LDM: begin
                            dst_d   = info.dst;
                            maddr_d = hl;
                            st_d    = ST_MRD;
                        end
                        OC_STM: begin
                            wbyte_d = rdat;
                            maddr_d = hl;
                            st_d    = ST_MWR;
                        end
                        OC_PFX: begin
                            usey_d = info.use_y;
                            st_d   = ST_XFETCH;
                        end
                        OC_HALT: st_d = ST_HALT;
                        default: ill_d = 1'b1;
                    endcase
                end
                ST_XFETCH: begin
                    pc_d = pc_q + 1'b1;
                    case (info.cls)
                        OC_LDM: begin
                            dst_d = info.dst;
                            xwr_d = 1'b0;
                            st_d  = ST_DISP;
                        end
                        OC_STM: begin
                            wbyte_d = rdat;
                            xwr_d   = 1'b1;
                            st_d    = ST_DISP;
                        end
                        default: begin
                            ill_d = 1'b1;
                            st_d  = ST_FETCH;
                        end
                    endcase
                end
                ST_IMM: begin
                    pc_d  = pc_q + 1'b1;
                    g_we  = 1'b1;
                    ret_d = 1'b1;
                    st_d  = ST_FETCH;
                end
                ST_DISP: begin
                    pc_d    = pc_q + 1'b1;
                    maddr_d = ea;
                    st_d    = ST_CALC;
                end
                ST_CALC: st_d = xwr_q ? ST_MWR : ST_MRD;
                ST_MRD: begin
                    g_we  = 1'b1;
                    ret_d = 1'b1;
                    st_d  = ST_FETCH;
                end
                ST_MWR: begin
                    ret_d = 1'b1;
                    st_d  = ST_FETCH;
                end
                ST_HALT: st_d = ST_HALT;
                default: st_d = ST_FETCH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_FETCH;
            tcnt_q  <= '0;
            pc_q    <= RESET_PC;
            maddr_q <= '0;
            wbyte_q <= '0;
            dst_q   <= '0;
            usey_q  <= 1'b0;
            xwr_q   <= 1'b0;
            ret_q   <= 1'b0;
            ill_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            tcnt_q  <= tcnt_d;
            pc_q    <= pc_d;
            maddr_q <= maddr_d;
            wbyte_q <= wbyte_d;
            dst_q   <= dst_d;
            usey_q  <= usey_d;
            xwr_q   <= xwr_d;
            ret_q   <= ret_d;
            ill_q   <= ill_d;
        end
    end

    // outputs
    always_comb begin
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        mem_addr = pc_q;
        unique case (st_q)
            ST_FETCH, ST_XFETCH, ST_IMM, ST_DISP: mem_rd = 1'b1;
            ST_MRD: begin
                mem_rd   = 1'b1;
                mem_addr = maddr_q;
            end
            ST_MWR: begin
                mem_wr   = 1'b1;
                mem_addr = maddr_q;
            end
            default: mem_addr = pc_q;
        endcase
    end

    assign mem_wdata = wbyte_q;
    assign retire    = ret_q;
    assign illegal   = ill_q;
    assign halted    = (st_q == ST_HALT);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R5
    wr_addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R6
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr && !retire));

    // R10
    ret_ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(retire && illegal));

    // R12
    retire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);
endmodule

// File: tb/sim_ldseq_core.sv
module sim_ldseq_core;
    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] BASE       = 16'hFFFC;
    localparam int          TMAX       = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        dbg_we = 1'b0;
    logic [1:0]  dbg_sel = 2'd3;
    logic [15:0] dbg_val = '0;
    logic        retire, illegal, halted;

    logic [7:0]  mem [0:65535];
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic        er [TMAX], ew [TMAX], eret [TMAX], eill [TMAX];
    logic [15:0] ea [TMAX];
    logic        tr_rd [TMAX], tr_wr [TMAX], tr_ret [TMAX], tr_ill [TMAX], tr_halt [TMAX];
    logic [15:0] tr_addr [TMAX];
    int          ep, pp;
    logic [15:0] epc;
    int          hl_at, ix_at, iy_at;
    logic [15:0] hl_v, ix_v, iy_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

    ldseq_core #(.AW(16), .DW(8), .RESET_PC(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dbg_we(dbg_we), .dbg_sel(dbg_sel), .dbg_val(dbg_val),
        .retire(retire), .illegal(illegal), .halted(halted)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] rc(input int i);
        return (i == 6) ? 3'd7 : 3'(i);
    endfunction

    function automatic logic [7:0] vv(input int i);
        return 8'h21 + 8'(i) * 8'h13;
    endfunction

    task automatic clear_all();
        for (int a = 0; a < 65536; a++) mem[a] = 8'h00;
        for (int i = 0; i < TMAX; i++) begin
            er[i] = 0; ew[i] = 0; eret[i] = 0; eill[i] = 0; ea[i] = '0;
        end
        ep = 0; pp = 0; epc = BASE;
        hl_at = -1; ix_at = -1; iy_at = -1;
        hl_v = '0; ix_v = '0; iy_v = '0;
    endtask

    task automatic put(input logic [7:0] b);
        mem[BASE + 16'(pp)] = b;
        pp++;
    endtask

    task automatic seg(input int n, input logic r, input logic w, input logic [15:0] a);
        for (int i = 0; i < n; i++) begin
            er[ep] = r; ew[ep] = w; ea[ep] = a; ep++;
        end
    endtask

    task automatic pcseg(input int n);
        seg(n, 1'b1, 1'b0, epc);
        epc = epc + 16'd1;
    endtask

    task automatic i_mov(input logic [2:0] d, input logic [2:0] s);
        put({2'b01, d, s}); pcseg(4); eret[ep] = 1;
    endtask

    task automatic i_imm(input logic [2:0] d, input logic [7:0] v);
        put({2'b00, d, 3'b110}); put(v); pcseg(4); pcseg(3); eret[ep] = 1;
    endtask

    task automatic i_ldhl(input logic [2:0] d, input logic [15:0] hl);
        put({2'b01, d, 3'b110}); pcseg(4); seg(3, 1, 0, hl); eret[ep] = 1;
    endtask

    task automatic i_sthl(input logic [2:0] s, input logic [15:0] hl);
        put({5'b01110, s}); pcseg(4); seg(3, 0, 1, hl); eret[ep] = 1;
    endtask

    task automatic i_idx(input logic [7:0] pfx, input bit wr, input logic [2:0] r,
                         input logic [7:0] disp, input logic [15:0] base);
        put(pfx);
        put(wr ? {5'b01110, r} : {2'b01, r, 3'b110});
        put(disp);
        pcseg(4); pcseg(4); pcseg(3);
        seg(5, 0, 0, 16'h0);
        seg(3, !wr, wr, base + {{8{disp[7]}}, disp});
        eret[ep] = 1;
    endtask

    task automatic i_bad1(input logic [7:0] op);
        put(op); pcseg(4); eill[ep] = 1;
    endtask

    task automatic i_bad2(input logic [7:0] pfx, input logic [7:0] op);
        put(pfx); put(op); pcseg(4); pcseg(4); eill[ep] = 1;
    endtask

    task automatic run(input int ncyc);
        dbg_we = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int c = 0; c < ncyc; c++) begin
            dbg_we = 0; dbg_sel = 2'd3;
            if (c == hl_at)      begin dbg_we = 1; dbg_sel = 2'd0; dbg_val = hl_v; end
            else if (c == ix_at) begin dbg_we = 1; dbg_sel = 2'd1; dbg_val = ix_v; end
            else if (c == iy_at) begin dbg_we = 1; dbg_sel = 2'd2; dbg_val = iy_v; end
            tr_rd[c] = mem_rd; tr_wr[c] = mem_wr; tr_addr[c] = mem_addr;
            tr_ret[c] = retire; tr_ill[c] = illegal; tr_halt[c] = halted;
            @(negedge clk);
        end
        dbg_we = 0; rst_n = 0;
        @(negedge clk);
    endtask

    task automatic cmp_trace(input string req);
        int bad_i = -1;
        logic [31:0] a = '0, e = '0;
        for (int i = 0; i < ep; i++) begin
            if (bad_i < 0 && (tr_rd[i] !== er[i] || tr_wr[i] !== ew[i] ||
                ((er[i] || ew[i]) && tr_addr[i] !== ea[i]) ||
                tr_ret[i+1] !== eret[i+1] || tr_ill[i+1] !== eill[i+1])) begin
                bad_i = i;
                a = {tr_addr[i], 4'h0, tr_rd[i], tr_wr[i], tr_ret[i+1], tr_ill[i+1], 8'(i)};
                e = {ea[i], 4'h0, er[i], ew[i], eret[i+1], eill[i+1], 8'(i)};
            end
        end
        chk(bad_i < 0, req, a, e);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R2 R3 R7 R9 R12: sweep every copy pair, observe all registers by Y-indexed stores
        for (int d = 0; d < 7; d++) begin
            for (int s = 0; s < 7; s++) begin
                clear_all();
                iy_at = 0; iy_v = 16'h9000;
                for (int r = 0; r < 7; r++) i_imm(rc(r), vv(r));
                i_mov(rc(d), rc(s));
                for (int r = 0; r < 7; r++) i_idx(8'hFD, 1'b1, rc(r), 8'(r), 16'h9000);
                run(ep + 4);
                cmp_trace("R2 R3 R7 R9 R12 schedule");
                if (d == 0 && s == 0) chk(tr_addr[0] === BASE && tr_rd[0] === 1'b1,
                                          "R1 first fetch", 32'(tr_addr[0]), 32'(BASE));
                for (int r = 0; r < 7; r++)
                    chk(mem[16'h9000 + 16'(r)] === ((r == d) ? vv(s) : vv(r)),
                        "R2 copy result", 32'(mem[16'h9000 + 16'(r)]),
                        32'((r == d) ? vv(s) : vv(r)));
            end
        end

        // R4 R5: HL-addressed load and store
        clear_all();
        hl_at = 0; hl_v = 16'h4000; iy_at = 1; iy_v = 16'h9000;
        mem[16'h4000] = 8'hA5;
        i_ldhl(3'd7, 16'h4000);
        i_imm(3'd0, 8'h3C);
        i_sthl(3'd0, 16'h4000);
        i_idx(8'hFD, 1'b1, 3'd7, 8'h05, 16'h9000);
        run(ep + 4);
        cmp_trace("R4 R5 schedule");
        chk(mem[16'h4000] === 8'h3C, "R5 store at HL", 32'(mem[16'h4000]), 32'h3C);
        chk(mem[16'h9005] === 8'hA5, "R4 load from HL", 32'(mem[16'h9005]), 32'hA5);

        // R7 R8: both prefixes, negative/positive displacement, address wrap
        clear_all();
        ix_at = 0; ix_v = 16'h0010; iy_at = 1; iy_v = 16'h9000;
        mem[16'hFF90] = 8'h77; mem[16'h907F] = 8'h5A;
        i_idx(8'hDD, 1'b0, 3'd7, 8'h80, 16'h0010);
        i_idx(8'hFD, 1'b0, 3'd0, 8'h7F, 16'h9000);
        i_idx(8'hDD, 1'b1, 3'd7, 8'h7F, 16'h0010);
        i_idx(8'hFD, 1'b1, 3'd0, 8'h80, 16'h9000);
        run(ep + 4);
        cmp_trace("R7 R8 indexed schedule");
        chk(mem[16'h008F] === 8'h77, "R8 wrap below zero", 32'(mem[16'h008F]), 32'h77);
        chk(mem[16'h8F80] === 8'h5A, "R8 negative displacement", 32'(mem[16'h8F80]), 32'h5A);

        // R10: unsupported opcodes and bad prefix pairs are skipped
        clear_all();
        iy_at = 0; iy_v = 16'h9000;
        i_bad1(8'h00);
        i_bad2(8'hDD, 8'h41);
        i_bad2(8'hDD, 8'hFD);
        i_bad2(8'hFD, 8'h76);
        i_imm(3'd7, 8'h99);
        i_idx(8'hFD, 1'b1, 3'd7, 8'h10, 16'h9000);
        run(ep + 4);
        cmp_trace("R10 illegal schedule");
        chk(mem[16'h9010] === 8'h99, "R10 execution resumes", 32'(mem[16'h9010]), 32'h99);

        // R11: side load of HL on the same edge as an instruction write to H
        clear_all();
        iy_at = 0; iy_v = 16'h9000; hl_at = 6; hl_v = 16'h1234;
        i_imm(3'd4, 8'hAB);
        i_idx(8'hFD, 1'b1, 3'd4, 8'h00, 16'h9000);
        i_idx(8'hFD, 1'b1, 3'd5, 8'h01, 16'h9000);
        run(ep + 4);
        cmp_trace("R11 R12 schedule");
        chk(mem[16'h9000] === 8'h12, "R11 side load wins on H", 32'(mem[16'h9000]), 32'h12);
        chk(mem[16'h9001] === 8'h34, "R11 side load of L", 32'(mem[16'h9001]), 32'h34);

        // R6: halt stops the sequencer
        clear_all();
        i_imm(3'd0, 8'h12);
        put(8'h76); pcseg(4);
        put(8'h3E); put(8'h55);
        run(60);
        cmp_trace("R6 before halt");
        begin
            bit ok = 1;
            for (int i = 0; i < 60; i++) begin
                if (i < ep && tr_halt[i] !== 1'b0) ok = 0;
                if (i >= ep && (tr_halt[i] !== 1'b1 || tr_rd[i] !== 1'b0 ||
                                tr_wr[i] !== 1'b0 || tr_ret[i] !== 1'b0)) ok = 0;
            end
            chk(ok, "R6 halted and quiet", 32'(ok), 32'h1);
        end

        // R1: reset state, then every register reads back as zero
        chk(halted === 1'b0 && mem_wr === 1'b0 && retire === 1'b0 && illegal === 1'b0,
            "R1 outputs in reset", {28'h0, halted, mem_wr, retire, illegal}, 32'h0);
        clear_all();
        for (int a = 16'h9000; a < 16'h9008; a++) mem[a] = 8'hEE;
        iy_at = 0; iy_v = 16'h9000;
        for (int r = 0; r < 7; r++) i_idx(8'hFD, 1'b1, rc(r), 8'(r), 16'h9000);
        run(ep + 4);
        cmp_trace("R1 schedule");
        for (int r = 0; r < 7; r++)
            chk(mem[16'h9000 + 16'(r)] === 8'h00, "R1 register cleared",
                32'(mem[16'h9000 + 16'(r)]), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule